// File: doc/BRIEF.md
# Lithium-Ion Charge Sequencer

This block is the digital controller of a single-cell lithium-ion charger. It takes seven raw comparator flags from the analog side and filters each through its own deglitch timer. From the filtered flags it steps a charge cycle through its phases. Its outputs tell the analog current source whether to run and at which rate, drive a status LED, and pass the end-of-charge threshold choice back to the analog side.

The seven flags are:
- adapter present;
- USB power present;
- battery above the full-rate threshold;
- constant-voltage level reached;
- charge current below the end-of-charge level;
- battery below the restart level;
- battery temperature out of window.

All timing comes from a millisecond tick. The tick is made by dividing the system clock by `TICK_DIV`. The deglitch windows and the safety limits are counted in ticks, so a simulation can shrink every time scale without changing the sequence.

States:
- IDLE: no charging.
- PREQ: pre-qualification, reduced current.
- CC: constant current at full rate.
- CV: constant voltage.
- TOPOFF: timed finishing phase.
- DONE: charge complete.
- SUSP: suspended for battery temperature.
- LOCK: latched safety-timer fault.

Transitions:
- IDLE→PREQ on filtered power present.
- PREQ→CC on the above-threshold flag.
- CC→PREQ on its loss.
- CC→CV on CV reached.
- CV→TOPOFF on low current.
- TOPOFF→DONE on top-off expiry.
- DONE→PREQ on the restart flag.
- PREQ/CC/CV/TOPOFF→SUSP on a temperature fault.
- SUSP→CC or SUSP→PREQ on temperature recovery.
- Any charging state or SUSP→LOCK on a safety-timer expiry.
- LOCK→IDLE on the clear input.
- Any state→IDLE when both raw power flags are low.

Top module: `chg_sequencer`

## Requirements
- R1: After reset, `state_oh` is 8'h01 (IDLE), and `chg_en`, `full_rate` and `led` are 0. The one-hot bit positions are IDLE 0, PREQ 1, CC 2, CV 3, TOPOFF 4, DONE 5, SUSP 6 and LOCK 7.
- R2: A rising adapter or USB flag moves IDLE to PREQ only after it has stayed high for `PWR_MS` consecutive ticks. A pulse shorter than `PWR_MS-1` ticks is ignored and the block stays in IDLE. On entering PREQ the block drives `chg_en`=1 and `full_rate`=0.
- R3: PREQ moves to CC after the above-threshold flag has stayed high for `PHASE_MS` ticks. CC returns to PREQ after the flag has stayed low for `PHASE_MS` ticks. `full_rate` is 1 in CC, CV and TOPOFF and 0 elsewhere.
- R4: CC moves to CV, and CV moves to TOPOFF, each after its flag has stayed high for `PHASE_MS` ticks. `eoc_sel_out` equals `eoc_sel_in` at all times.
- R5: TOPOFF lasts `TOPOFF_MS` ticks and then moves to DONE. In DONE, `chg_en` and `led` are 0.
- R6: In DONE, the restart flag held high for `PHASE_MS` ticks starts a new cycle in PREQ.
- R7: The pre-qualification timer runs in PREQ and SUSP and is cleared in every other state. When it reaches `PREQ_MS` ticks the block enters LOCK. LOCK holds regardless of the flags until `fault_clr` or power loss. `fault_clr` sends it to IDLE on the next edge.
- R8: The cycle timer runs in PREQ, CC, CV, TOPOFF and SUSP. It is cleared in IDLE, DONE and LOCK. When it reaches `TOTAL_MS` ticks the block enters LOCK.
- R9: A high temperature flag moves a charging state to SUSP within two clocks, which drops `chg_en`. After the flag has stayed low for `PHASE_MS` ticks, the block resumes in CC if the filtered above-threshold flag is high, and in PREQ otherwise.
- R10: When both raw power flags are low, the next edge moves the block to IDLE from any state.
- R11: `led` is 1 in PREQ, CC, CV and TOPOFF. In SUSP and LOCK it starts at 1 and toggles every `BLINK_MS` ticks. It is 0 in IDLE and DONE.
- R12: A safety-timer expiry wins over a temperature recovery in the same cycle, and the block enters LOCK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| fault_clr | input | 1 | Synchronous clear of the latched safety fault |
| ac_raw | input | 1 | Adapter present flag, raw |
| usb_raw | input | 1 | USB power present flag, raw |
| vfull_raw | input | 1 | Battery above full-rate threshold, raw |
| cv_raw | input | 1 | Constant-voltage level reached, raw |
| eoc_raw | input | 1 | Charge current below end-of-charge level, raw |
| restart_raw | input | 1 | Battery below restart level, raw |
| hot_raw | input | 1 | Battery temperature out of window, raw |
| eoc_sel_in | input | 1 | End-of-charge threshold choice (1: 5 %, 0: 10 %) |
| state_oh | output | 8 | One-hot state vector |
| chg_en | output | 1 | Charge current source enable |
| full_rate | output | 1 | 1 selects full-rate current, 0 selects pre-qualification current |
| eoc_sel_out | output | 1 | Threshold choice passed to the analog side |
| led | output | 1 | Status LED drive |

## Verification
The pre-qualification timer expiry and the temperature-recovery deglitch can complete on the same tick, because the timer keeps running during SUSP. The bench enters PREQ and raises the temperature flag at once. It then sweeps the release of the flag over eight offsets, so that recovery completes before, on and after the expiry tick. Every offset must end in LOCK inside the expiry window. If recovery completes first, the block only passes briefly through PREQ on its way there.

// File: rtl/chg_pkg.sv
`timescale 1ns/1ps
package chg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PREQ = 3'd1,
        ST_CC   = 3'd2,
        ST_CV   = 3'd3,
        ST_TOP  = 3'd4,
        ST_DONE = 3'd5,
        ST_SUSP = 3'd6,
        ST_LOCK = 3'd7
    } chg_state_t;

    localparam int NUM_STATES = 8;
    localparam int NUM_FLAGS  = 7;

    // flag slots in the filter bank
    localparam int FL_AC      = 0;
    localparam int FL_USB     = 1;
    localparam int FL_VFULL   = 2;
    localparam int FL_CV      = 3;
    localparam int FL_EOC     = 4;
    localparam int FL_RESTART = 5;
    localparam int FL_HOT     = 6;

    // filter variants: 0 both edges filtered, 1 low passes at once, 2 high passes at once
    function automatic int flag_mode(int idx);
        if (idx == FL_AC || idx == FL_USB) return 1;
        if (idx == FL_HOT) return 2;
        return 0;
    endfunction

    function automatic int flag_ms(int idx, int pwr_ms, int phase_ms);
        return (idx <= FL_USB) ? pwr_ms : phase_ms;
    endfunction

endpackage

// File: rtl/chg_tick.sv
`timescale 1ns/1ps
module chg_tick #(
    parameter int TICK_DIV = 2000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(TICK_DIV);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                            div_q <= '0;
        else if (div_q == CW'(TICK_DIV - 1))   div_q <= '0;
        else                                   div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == CW'(TICK_DIV - 1));

endmodule

// File: rtl/chg_deglitch.sv
`timescale 1ns/1ps
module chg_deglitch #(
    parameter int LIMIT = 10,
    parameter int MODE  = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic filt
);
    localparam int CW         = $clog2(LIMIT + 1);
    localparam bit FAST_LOW   = (MODE == 1);
    localparam bit FAST_HIGH  = (MODE == 2);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt  <= 1'b0;
            run_q <= '0;
        end else if (raw == filt) begin
            run_q <= '0;
        end else if ((FAST_LOW && !raw) || (FAST_HIGH && raw)) begin
            filt  <= raw;
            run_q <= '0;
        end else if (tick) begin
            if (run_q == CW'(LIMIT - 1)) begin
                filt  <= raw;
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // a filtered edge only ever follows what the raw flag showed on the prior edge
    assert_filter_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt) |-> (filt == $past(raw)));

endmodule

// File: rtl/chg_mscount.sv
`timescale 1ns/1ps
module chg_mscount #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] ms_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run)                     ms_q <= '0;
        else if (tick) begin
            if (ms_q == CW'(LIMIT - 1))         ms_q <= '0;
            else                                ms_q <= ms_q + 1'b1;
        end
    end

    assign expire = run && tick && (ms_q == CW'(LIMIT - 1));

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ms_q < CW'(LIMIT));

endmodule

// File: rtl/chg_sequencer.sv
`timescale 1ns/1ps
module chg_sequencer
    import chg_pkg::*;
#(
    parameter int TICK_DIV  = 2000,
    parameter int PWR_MS    = 32,
    parameter int PHASE_MS  = 10,
    parameter int TOPOFF_MS = 1260000,
    parameter int PREQ_MS   = 3600000,
    parameter int TOTAL_MS  = 36000000,
    parameter int BLINK_MS  = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fault_clr,
    input  logic       ac_raw,
    input  logic       usb_raw,
    input  logic       vfull_raw,
    input  logic       cv_raw,
    input  logic       eoc_raw,
    input  logic       restart_raw,
    input  logic       hot_raw,
    input  logic       eoc_sel_in,
    output logic [7:0] state_oh,
    output logic       chg_en,
    output logic       full_rate,
    output logic       eoc_sel_out,
    output logic       led
);
    chg_state_t st, nx;

    logic                 tick;
    logic [NUM_FLAGS-1:0] raw_v, flt_v;
    logic                 pwr_raw, pwr_f;
    logic                 preq_exp, cyc_exp, top_exp, blink_exp;
    logic                 run_preq, run_cyc, run_top, run_blink;
    logic                 timeout;
    logic                 blink_q;

    chg_tick #(.TICK_DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

    assign raw_v = {hot_raw, restart_raw, eoc_raw, cv_raw, vfull_raw, usb_raw, ac_raw};

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        chg_deglitch #(
            .LIMIT(flag_ms(g, PWR_MS, PHASE_MS)),
            .MODE (flag_mode(g))
        ) u_dg (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .raw(raw_v[g]), .filt(flt_v[g])
        );
    end

    assign pwr_raw = ac_raw | usb_raw;
    assign pwr_f   = flt_v[FL_AC] | flt_v[FL_USB];

    // timer run conditions
    assign run_preq  = (st == ST_PREQ) || (st == ST_SUSP);
    assign run_cyc   = (st == ST_PREQ) || (st == ST_CC) || (st == ST_CV) ||
                       (st == ST_TOP)  || (st == ST_SUSP);
    assign run_top   = (st == ST_TOP);
    assign run_blink = (st == ST_SUSP) || (st == ST_LOCK);

    chg_mscount #(.LIMIT(PREQ_MS))   u_preq_tmr  (.clk(clk), .rst_n(rst_n), .tick(tick),
                                                  .run(run_preq),  .expire(preq_exp));
    chg_mscount #(.LIMIT(TOTAL_MS))  u_cyc_tmr   (.clk(clk), .rst_n(rst_n), .tick(tick),
                                                  .run(run_cyc),   .expire(cyc_exp));
    chg_mscount #(.LIMIT(TOPOFF_MS)) u_top_tmr   (.clk(clk), .rst_n(rst_n), .tick(tick),
                                                  .run(run_top),   .expire(top_exp));
    chg_mscount #(.LIMIT(BLINK_MS))  u_blink_tmr (.clk(clk), .rst_n(rst_n), .tick(tick),
                                                  .run(run_blink), .expire(blink_exp));

    assign timeout = preq_exp | cyc_exp;

    // next state: power loss, then clear, then safety expiry, then temperature, then phase flags
    always_comb begin
        nx = st;
        if (!pwr_raw) begin
            nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: if (pwr_f) nx = ST_PREQ;
                ST_PREQ: begin
                    if (timeout)                  nx = ST_LOCK;
                    else if (flt_v[FL_HOT])       nx = ST_SUSP;
                    else if (flt_v[FL_VFULL])     nx = ST_CC;
                end
                ST_CC: begin
                    if (timeout)                  nx = ST_LOCK;
                    else if (flt_v[FL_HOT])       nx = ST_SUSP;
                    else if (!flt_v[FL_VFULL])    nx = ST_PREQ;
                    else if (flt_v[FL_CV])        nx = ST_CV;
                end
                ST_CV: begin
                    if (timeout)                  nx = ST_LOCK;
                    else if (flt_v[FL_HOT])       nx = ST_SUSP;
                    else if (flt_v[FL_EOC])       nx = ST_TOP;
                end
                ST_TOP: begin
                    if (timeout)                  nx = ST_LOCK;
                    else if (flt_v[FL_HOT])       nx = ST_SUSP;
                    else if (top_exp)             nx = ST_DONE;
                end
                ST_DONE: if (flt_v[FL_RESTART]) nx = ST_PREQ;
                ST_SUSP: begin
                    if (timeout)                  nx = ST_LOCK;
                    else if (!flt_v[FL_HOT])      nx = flt_v[FL_VFULL] ? ST_CC : ST_PREQ;
                end
                ST_LOCK: if (fault_clr) nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run_blink) blink_q <= 1'b1;
        else if (blink_exp)       blink_q <= ~blink_q;
    end

    for (genvar s = 0; s < NUM_STATES; s++) begin : g_oh
        assign state_oh[s] = (st == chg_state_t'(3'(s)));
    end

    assign eoc_sel_out = eoc_sel_in;

    always_comb begin
        unique case (st)
            ST_IDLE, ST_DONE: begin chg_en = 1'b0; full_rate = 1'b0; led = 1'b0;    end
            ST_PREQ:          begin chg_en = 1'b1; full_rate = 1'b0; led = 1'b1;    end
            ST_CC, ST_CV,
            ST_TOP:           begin chg_en = 1'b1; full_rate = 1'b1; led = 1'b1;    end
            ST_SUSP, ST_LOCK: begin chg_en = 1'b0; full_rate = 1'b0; led = blink_q; end
        endcase
    end

    assert_idle_on_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ac_raw || usb_raw) |=> state_oh[0]);

    assert_suspend_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_en && hot_raw && (ac_raw || usb_raw)) |=> ##1 !chg_en);

    assert_lock_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[7] && (ac_raw || usb_raw) && !fault_clr) |=> state_oh[7]);

    assert_rate_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full_rate |-> chg_en);

    assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_oh[5] |-> (!chg_en && !led));

endmodule

// File: tb/chg_sequencer_bench.sv
`timescale 1ns/1ps
module chg_sequencer_bench;
    localparam int D   = 4;
    localparam int PW  = 8;
    localparam int PH  = 3;
    localparam int TOP = 20;
    localparam int PQ  = 60;
    localparam int TOT = 200;
    localparam int BL  = 5;

    localparam logic [7:0] S_IDLE = 8'h01, S_PREQ = 8'h02, S_CC   = 8'h04, S_CV   = 8'h08,
                           S_TOP  = 8'h10, S_DONE = 8'h20, S_SUSP = 8'h40, S_LOCK = 8'h80;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, fault_clr, ac_raw, usb_raw, vfull_raw, cv_raw, eoc_raw, restart_raw, hot_raw, eoc_sel_in;
    logic [7:0] state_oh;
    logic chg_en, full_rate, eoc_sel_out, led;

    chg_sequencer #(
        .TICK_DIV(D), .PWR_MS(PW), .PHASE_MS(PH), .TOPOFF_MS(TOP),
        .PREQ_MS(PQ), .TOTAL_MS(TOT), .BLINK_MS(BL)
    ) u_chg_sequencer (
        .clk(clk), .rst_n(rst_n), .fault_clr(fault_clr), .ac_raw(ac_raw), .usb_raw(usb_raw),
        .vfull_raw(vfull_raw), .cv_raw(cv_raw), .eoc_raw(eoc_raw), .restart_raw(restart_raw),
        .hot_raw(hot_raw), .eoc_sel_in(eoc_sel_in), .state_oh(state_oh), .chg_en(chg_en),
        .full_rate(full_rate), .eoc_sel_out(eoc_sel_out), .led(led)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    localparam int PW_LO = (PW - 1) * D;
    localparam int PW_HI = PW * D + 2;
    localparam int PH_LO = (PH - 1) * D;
    localparam int PH_HI = PH * D + 2;

    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // state must first appear within lo..hi negedges from now
    task automatic win(logic [7:0] exp, int lo, int hi, string tag);
        int hit = 0;
        for (int n = 1; n <= hi; n++) begin
            @(negedge clk);
            if (state_oh == exp) begin
                hit = n;
                break;
            end
        end
        check(hit != 0 && hit >= lo, tag, hit, lo);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_toggles(int n, output int t);
        logic prev;
        t = 0;
        prev = led;
        repeat (n) begin
            @(negedge clk);
            if (led !== prev) t++;
            prev = led;
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int t;
        rst_n = 1'b0; fault_clr = 1'b0; ac_raw = 1'b0; usb_raw = 1'b0; vfull_raw = 1'b0;
        cv_raw = 1'b0; eoc_raw = 1'b0; restart_raw = 1'b0; hot_raw = 1'b0; eoc_sel_in = 1'b0;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1 reset state
        check(state_oh == S_IDLE, "R1 state", state_oh, S_IDLE);
        check(chg_en == 1'b0 && full_rate == 1'b0, "R1 enables", {chg_en, full_rate}, 0);
        check(led == 1'b0, "R1 led", led, 0);

        // R2 short pulse is ignored, long one starts charging
        ac_raw = 1'b1;
        wait_cyc(PW_LO - 6);
        ac_raw = 1'b0;
        wait_cyc(40);
        check(state_oh == S_IDLE, "R2 glitch ignored", state_oh, S_IDLE);
        check(led == 1'b0, "R2 glitch led", led, 0);
        usb_raw = 1'b1;
        win(S_PREQ, PW_LO, PW_HI, "R2 insertion window");
        check(chg_en == 1'b1 && full_rate == 1'b0, "R2 prequal outputs", {chg_en, full_rate}, 2);
        check(led == 1'b1, "R11 solid while charging", led, 1);

        // R3 prequal <-> full rate
        vfull_raw = 1'b1;
        win(S_CC, PH_LO, PH_HI, "R3 to CC");
        check(full_rate == 1'b1, "R3 full rate in CC", full_rate, 1);
        vfull_raw = 1'b0;
        win(S_PREQ, PH_LO, PH_HI, "R3 back to PREQ");
        check(full_rate == 1'b0, "R3 reduced in PREQ", full_rate, 0);
        vfull_raw = 1'b1;
        win(S_CC, PH_LO, PH_HI, "R3 to CC again");

        // R4 threshold passthrough and CC -> CV -> TOPOFF
        eoc_sel_in = 1'b1;
        wait_cyc(1);
        check(eoc_sel_out == 1'b1, "R4 sel high", eoc_sel_out, 1);
        eoc_sel_in = 1'b0;
        wait_cyc(1);
        check(eoc_sel_out == 1'b0, "R4 sel low", eoc_sel_out, 0);
        cv_raw = 1'b1;
        win(S_CV, PH_LO, PH_HI, "R4 to CV");
        eoc_raw = 1'b1;
        win(S_TOP, PH_LO, PH_HI, "R4 to TOPOFF");
        check(full_rate == 1'b1 && chg_en == 1'b1, "R4 topoff charging", {chg_en, full_rate}, 3);

        // R5 top-off duration
        win(S_DONE, (TOP - 1) * D, TOP * D + 2, "R5 topoff window");
        check(chg_en == 1'b0, "R5 done no charge", chg_en, 0);
        check(led == 1'b0, "R11 led off in done", led, 0);
        cv_raw = 1'b0;
        eoc_raw = 1'b0;
        wait_cyc(20);
        check(state_oh == S_DONE, "R6 stays done without restart", state_oh, S_DONE);

        // R6 restart
        restart_raw = 1'b1;
        win(S_PREQ, PH_LO, PH_HI, "R6 restart to PREQ");
        win(S_CC, 1, 1, "R6 then CC");
        restart_raw = 1'b0;

        // R9 temperature suspend, resume into CC
        hot_raw = 1'b1;
        win(S_SUSP, 1, 2, "R9 suspend from CC");
        check(chg_en == 1'b0, "R9 charge stopped", chg_en, 0);
        check(led == 1'b1, "R11 blink starts on", led, 1);
        count_toggles(50, t);
        check(t == 2, "R11 blink in suspend", t, 2);
        hot_raw = 1'b0;
        win(S_CC, PH_LO, PH_HI, "R9 resume to CC");
        vfull_raw = 1'b0;
        win(S_PREQ, PH_LO, PH_HI, "R3 drop to PREQ");
        hot_raw = 1'b1;
        win(S_SUSP, 1, 2, "R9 suspend from PREQ");
        hot_raw = 1'b0;
        win(S_PREQ, PH_LO, PH_HI, "R9 resume to PREQ");

        // R10 power removal
        usb_raw = 1'b0;
        win(S_IDLE, 1, 1, "R10 removal to IDLE");
        check(chg_en == 1'b0 && led == 1'b0, "R10 idle outputs", {chg_en, led}, 0);

        // R7 prequal limit and latch
        usb_raw = 1'b1;
        win(S_PREQ, PW_LO, PW_HI, "R2 reinsertion");
        win(S_LOCK, (PQ - 1) * D, PQ * D + 2, "R7 prequal limit");
        check(chg_en == 1'b0, "R7 lock no charge", chg_en, 0);
        count_toggles(50, t);
        check(t == 2, "R11 blink in lock", t, 2);
        vfull_raw = 1'b1;
        wait_cyc(30);
        check(state_oh == S_LOCK, "R7 lock holds", state_oh, S_LOCK);
        fault_clr = 1'b1;
        win(S_IDLE, 1, 1, "R7 clear to IDLE");
        fault_clr = 1'b0;
        win(S_PREQ, 1, 1, "R7 restart after clear");
        win(S_CC, 1, 1, "R8 into CC");

        // R8 whole-cycle limit
        win(S_LOCK, (TOT - 1) * D - 1, TOT * D + 2, "R8 cycle limit");
        vfull_raw = 1'b0;
        wait_cyc(20);

        // R12 sweep: recovery against prequal expiry
        for (int off = 0; off < 8; off++) begin
            int k;
            k = 220 + 2 * off;
            fault_clr = 1'b1;
            win(S_IDLE, 1, 1, "R12 clear");
            fault_clr = 1'b0;
            win(S_PREQ, 1, 1, "R12 enter PREQ");
            hot_raw = 1'b1;
            wait_cyc(k);
            hot_raw = 1'b0;
            win(S_LOCK, ((PQ - 1) * D - k > 1) ? (PQ - 1) * D - k : 1, PQ * D + 2 - k, "R12 expiry wins");
        end

        // R10 removal also clears a latched fault
        ac_raw = 1'b0;
        usb_raw = 1'b0;
        win(S_IDLE, 1, 1, "R10 removal from LOCK");
        ac_raw = 1'b1;
        win(S_PREQ, PW_LO, PW_HI, "R10 fresh cycle after removal");

        summary();
    end

endmodule